// File: doc/BRIEF.md
# SIMD Media Instruction Decoder

This block sits in the issue path of a 64-bit packed-media coprocessor. Each cycle that `in_valid` is high, it takes one 32-bit instruction word, together with the coprocessor-usable flag and the two status bits that enable the media unit. It checks, in a fixed order, whether the word may run at all. Then it turns the word into a compact operation code, an element format (eight bytes or four halfwords), three register indices, accumulator qualifiers, a shuffle sub-operation and an exception code. The decoded result is registered, so downstream stages see it one clock after the word was presented.

The checks run in this order. A word whose major opcode does not belong to the media unit passes through as a no-op. For a media word, the coprocessor-usable check comes first and the media-enable check second. Encoding validity is checked last, so a bad encoding only ever raises the reserved-instruction code. When any exception is raised, the operation code and every qualifier are forced to zero. This means no operation is dispatched.

Top module: `media_insn_decoder`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `out_valid` and `exc_code` to 0 on that edge, whatever `in_valid` holds.
- R2: The outputs update on a rising edge when `in_valid` is high, and `out_valid` is 1 in the following cycle. When `in_valid` is low at an edge, `out_valid` is 0 after it.
- R3: A word whose bits 31:26 differ from 6'b011110 gives `op_code`=0 and `exc_code`=0, whatever the flag and status inputs are.
- R4: For a media word (bits 31:26 = 6'b011110) with `cop_usable` low, `exc_code`=1 (coprocessor unusable). This holds whatever the status bits are and whether or not the encoding is valid.
- R5: For a media word with `cop_usable` high but `st_mx` or `st_fr` low, `exc_code`=2 (media disabled), even when the encoding is invalid.
- R6: For the formatted ops of R7, R8 and R9, the format selector is bits 25:21. Bit 21 = 0 gives `half_fmt`=0 (bytes). Bits 22:21 = 01 give `half_fmt`=1 (halfwords). Bits 22:21 = 11 give `exc_code`=3 (reserved) and `op_code`=0.
- R7: The function code is bits 5:0. The two-operand ops decode to these `op_code` values: add 001011→1, sub 001010→2, and 001100→3, or 001110→4, nor 001111→5, xor 001101→6, max 000111→7, min 000110→8, mul 110000→9, pickf 000010→10, pickt 000011→11, sll 010000→12, srl 010010→13.
- R8: The compares decode as equal 000001→15, less-than 000100→16 and less-or-equal 000101→17. If bits 10:6 are not zero, the word is reserved (`exc_code`=3).
- R9: The accumulator ops decode as add 110111→18, subtract 110110→19, multiply 110011→20 and multiply-subtract 110010→21. Bit 10 drives `acc_load` (1 = overwrite form, 0 = accumulate form). If bits 9:6 are not zero, the word is reserved.
- R10: Accumulator read (function 111111) gives `op_code`=22. Bits 25:22 select the slice: 1000→`acc_slice`=2 (high), 0100→1 (middle), 0000→0 (low). Any other value is reserved. Bit 21 gives `half_fmt`, and non-zero bits 20:11 are reserved.
- R11: Shuffle (function 011111) gives `op_code`=27, with the selector in bits 25:21. If selector bits 4 and 0 are both clear, bits 3:1 choose a byte form with `half_fmt`=0: 3 upsl→1, 4 pach→2, 6 mixh→3, 7 mixl→4. If selector bits 1:0 = 01, bits 4:2 choose a halfword form with `half_fmt`=1: 0 mixh→3, 1 mixl→4, 2 pach→2, 4 bfla→5, 6 repa→6, 7 repb→7. These numbers are the `shuf_sel` values. Every other selector is reserved.
- R12: The halfword-only ops decode as sra 010011→14, msgn 000000→23, rzs 100100→24, rnas 100101→25 and rnes 100110→26. They require bits 22:21 = 01 and give `half_fmt`=1; any other value is reserved.
- R13: A media word with any function code not listed above is reserved (`exc_code`=3). Whenever `exc_code` is non-zero, or the word is foreign, `op_code`, `half_fmt`, `acc_load`, `acc_slice` and `shuf_sel` are all 0.
- R14: Every accepted word registers `src_s` = bits 15:11, `src_t` = bits 20:16 and `dst` = bits 10:6, whatever the exception outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word present this cycle |
| insn | input | 32 | Instruction word |
| cop_usable | input | 1 | Coprocessor usable flag |
| st_mx | input | 1 | Media-unit enable status bit |
| st_fr | input | 1 | Wide register mode status bit |
| out_valid | output | 1 | Registered result valid |
| op_code | output | 5 | Decoded operation, 0 = none |
| half_fmt | output | 1 | 1 = four halfwords, 0 = eight bytes |
| src_s | output | 5 | First source register index |
| src_t | output | 5 | Second source register index |
| dst | output | 5 | Destination register index |
| acc_load | output | 1 | Accumulator overwrite form |
| acc_slice | output | 2 | Accumulator read slice (0 low, 1 middle, 2 high) |
| shuf_sel | output | 3 | Shuffle sub-operation, 0 = none |
| exc_code | output | 2 | 0 none, 1 coprocessor unusable, 2 media disabled, 3 reserved |

## Verification
The assertions take for granted that `in_valid`, `insn` and the flag and status inputs are known values at every rising edge after reset. They also assume that the status bits sampled with a word are the ones that word is judged against, so the properties relate the inputs at one edge to the outputs after it. The stimulus meets this by changing every input only on the falling edge and holding it across the following rising edge. It never leaves a field undriven.

// File: rtl/media_dec_pkg.sv
package media_dec_pkg;

    localparam int INSN_W   = 32;
    localparam int IDX_W    = 5;
    localparam int FUNC_W   = 6;
    localparam int MAJOR_W  = 6;
    localparam int BODY_W   = INSN_W - MAJOR_W;
    localparam int D_LSB    = FUNC_W;
    localparam int S_LSB    = D_LSB + IDX_W;
    localparam int T_LSB    = S_LSB + IDX_W;
    localparam int FSEL_LSB = T_LSB + IDX_W;
    localparam int OP_W     = 5;
    localparam int SHUF_W   = 3;
    localparam int SLICE_W  = 2;
    localparam int EXC_W    = 2;

    localparam logic [MAJOR_W-1:0] MEDIA_MAJOR = 6'b011110;

    localparam logic [FUNC_W-1:0] FN_ADD   = 6'b001011;
    localparam logic [FUNC_W-1:0] FN_SUB   = 6'b001010;
    localparam logic [FUNC_W-1:0] FN_AND   = 6'b001100;
    localparam logic [FUNC_W-1:0] FN_OR    = 6'b001110;
    localparam logic [FUNC_W-1:0] FN_NOR   = 6'b001111;
    localparam logic [FUNC_W-1:0] FN_XOR   = 6'b001101;
    localparam logic [FUNC_W-1:0] FN_MAX   = 6'b000111;
    localparam logic [FUNC_W-1:0] FN_MIN   = 6'b000110;
    localparam logic [FUNC_W-1:0] FN_MUL   = 6'b110000;
    localparam logic [FUNC_W-1:0] FN_PICKF = 6'b000010;
    localparam logic [FUNC_W-1:0] FN_PICKT = 6'b000011;
    localparam logic [FUNC_W-1:0] FN_SLL   = 6'b010000;
    localparam logic [FUNC_W-1:0] FN_SRL   = 6'b010010;
    localparam logic [FUNC_W-1:0] FN_SRA   = 6'b010011;
    localparam logic [FUNC_W-1:0] FN_CEQ   = 6'b000001;
    localparam logic [FUNC_W-1:0] FN_CLT   = 6'b000100;
    localparam logic [FUNC_W-1:0] FN_CLE   = 6'b000101;
    localparam logic [FUNC_W-1:0] FN_AADD  = 6'b110111;
    localparam logic [FUNC_W-1:0] FN_ASUB  = 6'b110110;
    localparam logic [FUNC_W-1:0] FN_AMUL  = 6'b110011;
    localparam logic [FUNC_W-1:0] FN_AMSUB = 6'b110010;
    localparam logic [FUNC_W-1:0] FN_ARD   = 6'b111111;
    localparam logic [FUNC_W-1:0] FN_MSGN  = 6'b000000;
    localparam logic [FUNC_W-1:0] FN_RZS   = 6'b100100;
    localparam logic [FUNC_W-1:0] FN_RNAS  = 6'b100101;
    localparam logic [FUNC_W-1:0] FN_RNES  = 6'b100110;
    localparam logic [FUNC_W-1:0] FN_SHFL  = 6'b011111;

    typedef enum logic [OP_W-1:0] {
        OP_NONE  = 5'd0,  OP_ADD   = 5'd1,  OP_SUB   = 5'd2,  OP_AND   = 5'd3,
        OP_OR    = 5'd4,  OP_NOR   = 5'd5,  OP_XOR   = 5'd6,  OP_MAX   = 5'd7,
        OP_MIN   = 5'd8,  OP_MUL   = 5'd9,  OP_PICKF = 5'd10, OP_PICKT = 5'd11,
        OP_SLL   = 5'd12, OP_SRL   = 5'd13, OP_SRA   = 5'd14, OP_CEQ   = 5'd15,
        OP_CLT   = 5'd16, OP_CLE   = 5'd17, OP_AADD  = 5'd18, OP_ASUB  = 5'd19,
        OP_AMUL  = 5'd20, OP_AMSUB = 5'd21, OP_ARD   = 5'd22, OP_MSGN  = 5'd23,
        OP_RZS   = 5'd24, OP_RNAS  = 5'd25, OP_RNES  = 5'd26, OP_SHFL  = 5'd27
    } op_e;

    typedef enum logic [SHUF_W-1:0] {
        SH_NONE = 3'd0, SH_UPSL = 3'd1, SH_PACH = 3'd2, SH_MIXH = 3'd3,
        SH_MIXL = 3'd4, SH_BFLA = 3'd5, SH_REPA = 3'd6, SH_REPB = 3'd7
    } shuf_e;

    typedef enum logic [SLICE_W-1:0] {
        SL_LOW = 2'd0, SL_MID = 2'd1, SL_HIGH = 2'd2
    } slice_e;

    typedef enum logic [EXC_W-1:0] {
        EXC_NONE = 2'd0, EXC_COP = 2'd1, EXC_MEDIA_OFF = 2'd2, EXC_RSVD = 2'd3
    } exc_e;

    typedef enum logic [2:0] {
        CAT_NONE, CAT_SEL, CAT_HALF, CAT_CMP, CAT_ACC, CAT_ARD, CAT_SHFL
    } cat_e;

    typedef struct packed {
        logic             vld;
        op_e              op;
        logic             half;
        logic [IDX_W-1:0] s;
        logic [IDX_W-1:0] t;
        logic [IDX_W-1:0] d;
        logic             load;
        slice_e           slice;
        shuf_e            shuf;
        exc_e             exc;
    } dec_s;

endpackage

// File: rtl/media_fmt_sel.sv
module media_fmt_sel (
    input  logic [1:0] sel_lo,
    output logic       is_half,
    output logic       is_rsvd
);
    always_comb begin
        is_half = (sel_lo == 2'b01);
        is_rsvd = (sel_lo == 2'b11);
    end
endmodule

// File: rtl/media_shfl_dec.sv
module media_shfl_dec
    import media_dec_pkg::*;
(
    input  logic [IDX_W-1:0] sel,
    output shuf_e            code,
    output logic             half,
    output logic             bad
);
    always_comb begin
        code = SH_NONE;
        half = 1'b0;
        bad  = 1'b0;
        if (!sel[4] && !sel[0]) begin
            case (sel[3:1])
                3'd3:    code = SH_UPSL;
                3'd4:    code = SH_PACH;
                3'd6:    code = SH_MIXH;
                3'd7:    code = SH_MIXL;
                default: bad  = 1'b1;
            endcase
        end else if (sel[1:0] == 2'b01) begin
            half = 1'b1;
            case (sel[4:2])
                3'd0:    code = SH_MIXH;
                3'd1:    code = SH_MIXL;
                3'd2:    code = SH_PACH;
                3'd4:    code = SH_BFLA;
                3'd6:    code = SH_REPA;
                3'd7:    code = SH_REPB;
                default: bad  = 1'b1;
            endcase
        end else begin
            bad = 1'b1;
        end
    end
endmodule

// File: rtl/media_op_dec.sv
module media_op_dec
    import media_dec_pkg::*;
(
    input  logic [BODY_W-1:0] body,
    output op_e               op,
    output logic              half,
    output logic              load,
    output slice_e            slice,
    output shuf_e             shuf,
    output logic              bad
);
    logic [IDX_W-1:0]  fsel;
    logic [FUNC_W-1:0] func;
    logic              f_half, f_rsvd;
    shuf_e             sh_code;
    logic              sh_half, sh_bad;
    cat_e              cat;
    op_e               op_raw;

    assign fsel = body[FSEL_LSB +: IDX_W];
    assign func = body[FUNC_W-1:0];

    media_fmt_sel u_fmt (
        .sel_lo  (fsel[1:0]),
        .is_half (f_half),
        .is_rsvd (f_rsvd)
    );

    media_shfl_dec u_shfl (
        .sel  (fsel),
        .code (sh_code),
        .half (sh_half),
        .bad  (sh_bad)
    );

    // function code -> operation and encoding class
    always_comb begin
        cat    = CAT_NONE;
        op_raw = OP_NONE;
        case (func)
            FN_ADD:   begin op_raw = OP_ADD;   cat = CAT_SEL;  end
            FN_SUB:   begin op_raw = OP_SUB;   cat = CAT_SEL;  end
            FN_AND:   begin op_raw = OP_AND;   cat = CAT_SEL;  end
            FN_OR:    begin op_raw = OP_OR;    cat = CAT_SEL;  end
            FN_NOR:   begin op_raw = OP_NOR;   cat = CAT_SEL;  end
            FN_XOR:   begin op_raw = OP_XOR;   cat = CAT_SEL;  end
            FN_MAX:   begin op_raw = OP_MAX;   cat = CAT_SEL;  end
            FN_MIN:   begin op_raw = OP_MIN;   cat = CAT_SEL;  end
            FN_MUL:   begin op_raw = OP_MUL;   cat = CAT_SEL;  end
            FN_PICKF: begin op_raw = OP_PICKF; cat = CAT_SEL;  end
            FN_PICKT: begin op_raw = OP_PICKT; cat = CAT_SEL;  end
            FN_SLL:   begin op_raw = OP_SLL;   cat = CAT_SEL;  end
            FN_SRL:   begin op_raw = OP_SRL;   cat = CAT_SEL;  end
            FN_SRA:   begin op_raw = OP_SRA;   cat = CAT_HALF; end
            FN_MSGN:  begin op_raw = OP_MSGN;  cat = CAT_HALF; end
            FN_RZS:   begin op_raw = OP_RZS;   cat = CAT_HALF; end
            FN_RNAS:  begin op_raw = OP_RNAS;  cat = CAT_HALF; end
            FN_RNES:  begin op_raw = OP_RNES;  cat = CAT_HALF; end
            FN_CEQ:   begin op_raw = OP_CEQ;   cat = CAT_CMP;  end
            FN_CLT:   begin op_raw = OP_CLT;   cat = CAT_CMP;  end
            FN_CLE:   begin op_raw = OP_CLE;   cat = CAT_CMP;  end
            FN_AADD:  begin op_raw = OP_AADD;  cat = CAT_ACC;  end
            FN_ASUB:  begin op_raw = OP_ASUB;  cat = CAT_ACC;  end
            FN_AMUL:  begin op_raw = OP_AMUL;  cat = CAT_ACC;  end
            FN_AMSUB: begin op_raw = OP_AMSUB; cat = CAT_ACC;  end
            FN_ARD:   begin op_raw = OP_ARD;   cat = CAT_ARD;  end
            FN_SHFL:  begin op_raw = OP_SHFL;  cat = CAT_SHFL; end
            default:  begin op_raw = OP_NONE;  cat = CAT_NONE; end
        endcase
    end

    // class-specific field checks and qualifiers
    always_comb begin
        op    = op_raw;
        half  = f_half;
        load  = 1'b0;
        slice = SL_LOW;
        shuf  = SH_NONE;
        bad   = 1'b0;
        case (cat)
            CAT_SEL:  bad = f_rsvd;
            CAT_HALF: begin
                half = 1'b1;
                bad  = !f_half;
            end
            CAT_CMP:  bad = f_rsvd || (body[D_LSB +: IDX_W] != '0);
            CAT_ACC:  begin
                load = body[D_LSB + IDX_W - 1];
                bad  = f_rsvd || (body[D_LSB +: IDX_W-1] != '0);
            end
            CAT_ARD:  begin
                half = fsel[0];
                bad  = (body[S_LSB +: 2*IDX_W] != '0);
                case (fsel[IDX_W-1:1])
                    4'b1000: slice = SL_HIGH;
                    4'b0100: slice = SL_MID;
                    4'b0000: slice = SL_LOW;
                    default: bad   = 1'b1;
                endcase
            end
            CAT_SHFL: begin
                half = sh_half;
                shuf = sh_code;
                bad  = sh_bad;
            end
            default:  bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/media_insn_decoder.sv
module media_insn_decoder
    import media_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic              cop_usable,
    input  logic              st_mx,
    input  logic              st_fr,
    output logic              out_valid,
    output logic [OP_W-1:0]   op_code,
    output logic              half_fmt,
    output logic [IDX_W-1:0]  src_s,
    output logic [IDX_W-1:0]  src_t,
    output logic [IDX_W-1:0]  dst,
    output logic              acc_load,
    output logic [SLICE_W-1:0] acc_slice,
    output logic [SHUF_W-1:0] shuf_sel,
    output logic [EXC_W-1:0]  exc_code
);
    dec_s   state_d, state_q;
    op_e    dec_op;
    logic   dec_half, dec_load, dec_bad;
    slice_e dec_slice;
    shuf_e  dec_shuf;

    media_op_dec u_op (
        .body  (insn[BODY_W-1:0]),
        .op    (dec_op),
        .half  (dec_half),
        .load  (dec_load),
        .slice (dec_slice),
        .shuf  (dec_shuf),
        .bad   (dec_bad)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = 1'b0;
        if (in_valid) begin
            state_d.vld   = 1'b1;
            state_d.s     = insn[S_LSB +: IDX_W];
            state_d.t     = insn[T_LSB +: IDX_W];
            state_d.d     = insn[D_LSB +: IDX_W];
            state_d.op    = OP_NONE;
            state_d.half  = 1'b0;
            state_d.load  = 1'b0;
            state_d.slice = SL_LOW;
            state_d.shuf  = SH_NONE;
            state_d.exc   = EXC_NONE;
            if (insn[INSN_W-1 -: MAJOR_W] == MEDIA_MAJOR) begin
                if (!cop_usable) begin
                    state_d.exc = EXC_COP;
                end else if (!(st_mx && st_fr)) begin
                    state_d.exc = EXC_MEDIA_OFF;
                end else if (dec_bad) begin
                    state_d.exc = EXC_RSVD;
                end else begin
                    state_d.op    = dec_op;
                    state_d.half  = dec_half;
                    state_d.load  = dec_load;
                    state_d.slice = dec_slice;
                    state_d.shuf  = dec_shuf;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign op_code   = state_q.op;
    assign half_fmt  = state_q.half;
    assign src_s     = state_q.s;
    assign src_t     = state_q.t;
    assign dst       = state_q.d;
    assign acc_load  = state_q.load;
    assign acc_slice = state_q.slice;
    assign shuf_sel  = state_q.shuf;
    assign exc_code  = state_q.exc;
endmodule

// File: rtl/media_insn_decoder_chk.sv
module media_insn_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [5:0] major,
    input logic [5:0] func,
    input logic [1:0] fsel_lo,
    input logic       cop_usable,
    input logic       st_mx,
    input logic       st_fr,
    input logic       out_valid,
    input logic [4:0] op_code,
    input logic       half_fmt,
    input logic       acc_load,
    input logic [1:0] acc_slice,
    input logic [2:0] shuf_sel,
    input logic [1:0] exc_code
);
    logic media;
    assign media = (major == 6'b011110);

    // R2: no output without an accepted word
    p_idle_no_valid_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R3: foreign words raise nothing and dispatch nothing
    p_foreign_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !media) |=> (out_valid && exc_code == 2'd0 && op_code == 5'd0));

    // R4: coprocessor check comes first
    p_cop_first_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && media && !cop_usable) |=> (exc_code == 2'd1));

    // R5: media enable check is second
    p_media_off_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && media && cop_usable && !(st_mx && st_fr)) |=> (exc_code == 2'd2));

    // R6: reserved format on a formatted op
    p_fmt_rsvd_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && media && cop_usable && st_mx && st_fr
         && func == 6'b001011 && fsel_lo == 2'b11) |=> (exc_code == 2'd3 && op_code == 5'd0));

    // R11: a shuffle sub-operation only accompanies the shuffle op
    p_shuf_only_shfl_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && shuf_sel != 3'd0) |-> (op_code == 5'd27));

    // R13: an exception suppresses every qualifier
    p_exc_suppress_r13: assert property (@(posedge clk) disable iff (rst)
        (out_valid && exc_code != 2'd0) |->
        (op_code == 5'd0 && !half_fmt && !acc_load && acc_slice == 2'd0 && shuf_sel == 3'd0));
endmodule

bind media_insn_decoder media_insn_decoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .major      (insn[31:26]),
    .func       (insn[5:0]),
    .fsel_lo    (insn[22:21]),
    .cop_usable (cop_usable),
    .st_mx      (st_mx),
    .st_fr      (st_fr),
    .out_valid  (out_valid),
    .op_code    (op_code),
    .half_fmt   (half_fmt),
    .acc_load   (acc_load),
    .acc_slice  (acc_slice),
    .shuf_sel   (shuf_sel),
    .exc_code   (exc_code)
);

// File: tb/media_insn_decoder_tb.sv
`timescale 1ns/1ps
module media_insn_decoder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic        cop_usable = 1'b0;
    logic        st_mx = 1'b0;
    logic        st_fr = 1'b0;
    logic        out_valid;
    logic [4:0]  op_code;
    logic        half_fmt;
    logic [4:0]  src_s, src_t, dst;
    logic        acc_load;
    logic [1:0]  acc_slice;
    logic [2:0]  shuf_sel;
    logic [1:0]  exc_code;

    always #2.5 clk = ~clk;

    media_insn_decoder u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
        .cop_usable(cop_usable), .st_mx(st_mx), .st_fr(st_fr),
        .out_valid(out_valid), .op_code(op_code), .half_fmt(half_fmt),
        .src_s(src_s), .src_t(src_t), .dst(dst), .acc_load(acc_load),
        .acc_slice(acc_slice), .shuf_sel(shuf_sel), .exc_code(exc_code)
    );

    typedef struct packed {
        logic [4:0] op;
        logic       half;
        logic       load;
        logic [1:0] slice;
        logic [2:0] shuf;
        logic [1:0] exc;
        logic [4:0] s;
        logic [4:0] t;
        logic [4:0] d;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_errs   = 0;

    function automatic logic [31:0] mk(logic [4:0] fs, logic [4:0] t, logic [4:0] s,
                                       logic [4:0] d, logic [5:0] fn);
        return {6'b011110, fs, t, s, d, fn};
    endfunction

    function automatic exp_t ref_dec(logic [31:0] w, logic cu, logic mx, logic fr);
        exp_t       e;
        logic [4:0] fs;
        logic       hf, rsv, bad;
        int         op;
        e   = '0;
        e.s = w[15:11];
        e.t = w[20:16];
        e.d = w[10:6];
        if (w[31:26] != 6'b011110) return e;
        if (!cu) begin e.exc = 2'd1; return e; end
        if (!(mx && fr)) begin e.exc = 2'd2; return e; end
        fs  = w[25:21];
        hf  = (fs[1:0] == 2'b01);
        rsv = (fs[1:0] == 2'b11);
        bad = 1'b0;
        case (w[5:0])
            6'b001011: op = 1;   6'b001010: op = 2;   6'b001100: op = 3;
            6'b001110: op = 4;   6'b001111: op = 5;   6'b001101: op = 6;
            6'b000111: op = 7;   6'b000110: op = 8;   6'b110000: op = 9;
            6'b000010: op = 10;  6'b000011: op = 11;  6'b010000: op = 12;
            6'b010010: op = 13;  6'b010011: op = 14;  6'b000001: op = 15;
            6'b000100: op = 16;  6'b000101: op = 17;  6'b110111: op = 18;
            6'b110110: op = 19;  6'b110011: op = 20;  6'b110010: op = 21;
            6'b111111: op = 22;  6'b000000: op = 23;  6'b100100: op = 24;
            6'b100101: op = 25;  6'b100110: op = 26;  6'b011111: op = 27;
            default:   op = 0;
        endcase
        e.op = op[4:0];
        if (op == 0) begin
            bad = 1'b1;
        end else if (op <= 13) begin
            bad = rsv; e.half = hf;
        end else if (op == 14 || (op >= 23 && op <= 26)) begin
            bad = !hf; e.half = 1'b1;
        end else if (op <= 17) begin
            bad = rsv || (w[10:6] != 0); e.half = hf;
        end else if (op <= 21) begin
            bad = rsv || (w[9:6] != 0); e.half = hf; e.load = w[10];
        end else if (op == 22) begin
            e.half = w[21];
            bad = (w[20:11] != 0);
            case (w[25:22])
                4'b1000: e.slice = 2'd2;
                4'b0100: e.slice = 2'd1;
                4'b0000: e.slice = 2'd0;
                default: bad = 1'b1;
            endcase
        end else begin
            if (fs[4] == 1'b0 && fs[0] == 1'b0) begin
                case (fs[3:1])
                    3'd3: e.shuf = 3'd1;
                    3'd4: e.shuf = 3'd2;
                    3'd6: e.shuf = 3'd3;
                    3'd7: e.shuf = 3'd4;
                    default: bad = 1'b1;
                endcase
            end else if (fs[1:0] == 2'b01) begin
                e.half = 1'b1;
                case (fs[4:2])
                    3'd0: e.shuf = 3'd3;
                    3'd1: e.shuf = 3'd4;
                    3'd2: e.shuf = 3'd2;
                    3'd4: e.shuf = 3'd5;
                    3'd6: e.shuf = 3'd6;
                    3'd7: e.shuf = 3'd7;
                    default: bad = 1'b1;
                endcase
            end else begin
                bad = 1'b1;
            end
        end
        if (bad) begin
            e.op = '0; e.half = 1'b0; e.load = 1'b0;
            e.slice = '0; e.shuf = '0; e.exc = 2'd3;
        end
        return e;
    endfunction

    task automatic push(logic [31:0] w, logic cu, logic mx, logic fr, string tag);
        @(negedge clk);
        insn       = w;
        cop_usable = cu;
        st_mx      = mx;
        st_fr      = fr;
        in_valid   = 1'b1;
        exp_q.push_back(ref_dec(w, cu, mx, fr));
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic check_bit(logic act, logic expv, string tag);
        n_checks++;
        if (act !== expv) begin
            n_errs++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, expv);
        end
    endtask

    // monitor: compare each result against the oldest expected item
    always @(negedge clk) begin
        exp_t act, e;
        string tg;
        if (out_valid === 1'b1) begin
            act = {op_code, half_fmt, acc_load, acc_slice, shuf_sel, exc_code, src_s, src_t, dst};
            n_checks++;
            if (exp_q.size() == 0) begin
                n_errs++;
                $display("FAIL R2 unexpected output actual=%h expected=none", act);
            end else begin
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                if (act !== e) begin
                    n_errs++;
                    $display("FAIL %s actual=%h expected=%h", tg, act, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    logic [5:0] fns [13] = '{6'b001011, 6'b001010, 6'b001100, 6'b001110, 6'b001111,
                             6'b001101, 6'b000111, 6'b000110, 6'b110000, 6'b000010,
                             6'b000011, 6'b010000, 6'b010010};

    initial begin
        // R1: reset state, also with a word offered during reset
        repeat (2) @(negedge clk);
        insn = mk(5'd0, 5'd1, 5'd2, 5'd3, 6'b001011);
        cop_usable = 1'b1; st_mx = 1'b1; st_fr = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check_bit(out_valid, 1'b0, "R1 out_valid in reset");
        check_bit(exc_code == 2'd0, 1'b1, "R1 exc_code in reset");
        in_valid = 1'b0;
        rst = 1'b0;

        // R7 and R6 and R14: two-operand ops in both formats
        for (int i = 0; i < 13; i++) begin
            push(mk(5'b00001, 5'(i), 5'(i + 7), 5'(31 - i), fns[i]), 1, 1, 1, "R7 half");
            push(mk(5'b10010, 5'(i + 3), 5'(i), 5'(i + 1), fns[i]), 1, 1, 1, "R7 byte");
        end
        push(mk(5'b00011, 5'd4, 5'd5, 5'd6, 6'b001011), 1, 1, 1, "R6 reserved fmt");
        push(mk(5'b11111, 5'd4, 5'd5, 5'd6, 6'b110000), 1, 1, 1, "R6 reserved fmt");
        push(mk(5'b01101, 5'd9, 5'd8, 5'd7, 6'b000110), 1, 1, 1, "R6 half via 01");
        push(mk(5'b00110, 5'd17, 5'd21, 5'd30, 6'b001101), 1, 1, 1, "R14 indices");

        // R8: compares
        push(mk(5'b00000, 5'd1, 5'd2, 5'd0, 6'b000001), 1, 1, 1, "R8 eq");
        push(mk(5'b00001, 5'd1, 5'd2, 5'd0, 6'b000100), 1, 1, 1, "R8 lt");
        push(mk(5'b00000, 5'd1, 5'd2, 5'd0, 6'b000101), 1, 1, 1, "R8 le");
        push(mk(5'b00000, 5'd1, 5'd2, 5'd3, 6'b000100), 1, 1, 1, "R8 nonzero dst");
        push(mk(5'b00011, 5'd1, 5'd2, 5'd0, 6'b000001), 1, 1, 1, "R8 reserved fmt");

        // R9: accumulator ops
        push(mk(5'b00000, 5'd1, 5'd2, 5'b10000, 6'b110111), 1, 1, 1, "R9 add load");
        push(mk(5'b00001, 5'd1, 5'd2, 5'b00000, 6'b110110), 1, 1, 1, "R9 sub acc");
        push(mk(5'b00001, 5'd1, 5'd2, 5'b10000, 6'b110011), 1, 1, 1, "R9 mul load");
        push(mk(5'b00000, 5'd1, 5'd2, 5'b00000, 6'b110010), 1, 1, 1, "R9 mulsub acc");
        push(mk(5'b00000, 5'd1, 5'd2, 5'b10100, 6'b110111), 1, 1, 1, "R9 low bits set");

        // R10: accumulator read slices
        push(mk(5'b10000, 5'd0, 5'd0, 5'd4, 6'b111111), 1, 1, 1, "R10 high byte");
        push(mk(5'b01001, 5'd0, 5'd0, 5'd5, 6'b111111), 1, 1, 1, "R10 mid half");
        push(mk(5'b00001, 5'd0, 5'd0, 5'd6, 6'b111111), 1, 1, 1, "R10 low half");
        push(mk(5'b11000, 5'd0, 5'd0, 5'd6, 6'b111111), 1, 1, 1, "R10 bad slice");
        push(mk(5'b10000, 5'd2, 5'd0, 5'd6, 6'b111111), 1, 1, 1, "R10 nonzero vt");

        // R11: every shuffle selector
        for (int f = 0; f < 32; f++)
            push(mk(5'(f), 5'd3, 5'd4, 5'd5, 6'b011111), 1, 1, 1, "R11 shuffle");

        // R12: halfword-only ops
        push(mk(5'b00001, 5'd1, 5'd2, 5'd3, 6'b010011), 1, 1, 1, "R12 sra half");
        push(mk(5'b00000, 5'd1, 5'd2, 5'd3, 6'b010011), 1, 1, 1, "R12 sra byte");
        push(mk(5'b10101, 5'd1, 5'd2, 5'd3, 6'b000000), 1, 1, 1, "R12 msgn");
        push(mk(5'b00001, 5'd1, 5'd0, 5'd3, 6'b100100), 1, 1, 1, "R12 rzs");
        push(mk(5'b00001, 5'd1, 5'd0, 5'd3, 6'b100101), 1, 1, 1, "R12 rnas");
        push(mk(5'b00011, 5'd1, 5'd0, 5'd3, 6'b100110), 1, 1, 1, "R12 rnes bad");
        push(mk(5'b00010, 5'd1, 5'd0, 5'd3, 6'b100100), 1, 1, 1, "R12 rzs bad");

        // R13: unlisted functions
        push(mk(5'b00000, 5'd1, 5'd2, 5'd3, 6'b101010), 1, 1, 1, "R13 unlisted");
        push(mk(5'b00001, 5'd1, 5'd2, 5'd3, 6'b111000), 1, 1, 1, "R13 unlisted");

        // R3: foreign major opcode
        push({6'b010001, 26'h1234567}, 1, 1, 1, "R3 foreign");
        push({6'b011111, 5'd0, 5'd1, 5'd2, 5'd3, 6'b001011}, 0, 0, 0, "R3 foreign cu0");

        // R4 and R5: check ordering
        push(mk(5'b00011, 5'd1, 5'd2, 5'd3, 6'b101010), 0, 1, 1, "R4 cop first");
        push(mk(5'b00000, 5'd1, 5'd2, 5'd3, 6'b001011), 0, 0, 0, "R4 cop and off");
        push(mk(5'b00000, 5'd1, 5'd2, 5'd3, 6'b001011), 1, 0, 1, "R5 mx clear");
        push(mk(5'b00000, 5'd1, 5'd2, 5'd3, 6'b001011), 1, 1, 0, "R5 fr clear");
        push(mk(5'b00011, 5'd1, 5'd2, 5'd3, 6'b101010), 1, 0, 0, "R5 before reserved");

        // R2: output drops when the strobe is low
        idle(1);
        @(negedge clk);
        check_bit(out_valid, 1'b0, "R2 idle");
        check_bit(exp_q.size() == 0, 1'b1, "R2 all results seen");

        // R1: reset mid-run clears a pending exception
        push(mk(5'b00000, 5'd1, 5'd2, 5'd3, 6'b001011), 0, 1, 1, "R4 before reset");
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        check_bit(out_valid, 1'b0, "R1 mid-run out_valid");
        check_bit(exc_code == 2'd0, 1'b1, "R1 mid-run exc_code");
        rst = 1'b0;
        in_valid = 1'b0;

        idle(3);
        check_bit(exp_q.size() == 0, 1'b1, "R2 drained");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule